// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This controller moves a processor core from one operating point to another. An operating point pairs a supply-voltage code with a PLL divider code. A small table holds the points, indexed so that a higher index is a faster and higher-voltage point. Software names a target index. A rising thermal-limit input forces the slowest point. The sequencer then talks to an external regulator and an external PLL through command/acknowledge handshakes and puts each step in the safe order.

The core is held stalled only while the PLL relocks. Regulator steps never stall it. A bounded wait guards every step. If a regulator or PLL acknowledge is missing, the sequencer flags an error, commands the last good point again and releases the core. After each transition the block holds the time it took, the stall time and the voltage swing, so a policy can judge whether changing point is worth the cost.

Top module: `dvfs_seq`

## Requirements
- R1: The table has LEVELS entries. After reset, entry i holds voltage code 8*(i+1) and divider code 4*(i+1). A table write replaces one entry. The current level resets to 0. A higher index counts as a higher operating point.
- R2: A software request is taken up one cycle after it is sampled. If the sequencer is busy, the request is held pending, and a newer request replaces an older one that has not yet been served.
- R3: When moving to a higher index, the new voltage code is commanded first. The new divider is commanded only after the regulator reports settled. An acknowledge is ignored in the first wait cycle after its command, and the two command pulses never coincide.
- R4: When moving to a lower index, the new divider is commanded first. The new voltage code is commanded only after the PLL reports lock.
- R5: Stall rises in the same cycle as a PLL command and falls on the edge that samples lock. For a lock that arrives after d cycles, stall is high for d+1 cycles. Stall is never high while the regulator is settling.
- R6: A request for the level already active produces a done pulse with no regulator or PLL command. Busy stays low and all three cost values read 0.
- R7: A rising edge of the thermal input requests level 0. It is served before any pending software request, and the software request is served afterwards.
- R8: If the regulator does not settle within SETTLE_TO cycles, err is set. The previous voltage code is commanded again (and, when the divider had already changed, the previous divider first), and the current level stays as it was.
- R9: If the PLL does not lock within LOCK_TO cycles, err is set and stall falls. The previous divider is commanded, then the previous voltage code on the next cycle when the voltage had already changed. The current level stays as it was.
- R10: Busy is high from the accepting edge until the final step. Done is a single-cycle pulse with busy low. err clears when the next request is accepted.
- R11: On completion, cost_cycles equals the edges from acceptance to the end: settle delay plus lock delay plus 2 for a normal move. cost_stall equals the stall cycles. cost_swing equals the absolute difference of the old and new voltage codes, or 0 after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | LW | Table entry to write |
| tbl_vcode | input | VW | Voltage code to store |
| tbl_dcode | input | DW | Divider code to store |
| req_valid | input | 1 | Software request strobe |
| req_level | input | LW | Requested table index |
| therm_alert | input | 1 | Thermal limit near (rising edge acts) |
| vreg_cmd_valid | output | 1 | One-cycle regulator command |
| vreg_cmd_code | output | VW | Commanded voltage code |
| vreg_settled | input | 1 | Regulator output settled |
| pll_cmd_valid | output | 1 | One-cycle PLL command |
| pll_cmd_div | output | DW | Commanded divider code |
| pll_locked | input | 1 | PLL lock indication |
| core_stall | output | 1 | Core stall during relock |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle end-of-transition pulse |
| err | output | 1 | Last transition timed out |
| cur_level | output | LW | Active table index |
| cost_cycles | output | CW | Duration of last transition |
| cost_stall | output | CW | Stall cycles of last transition |
| cost_swing | output | VW | Voltage code swing of last transition |

## Verification
A corrupted sequencing state shows up at once in the order of the command pulses: a divider pulse ahead of the voltage pulse on a speed-up, or two pulses too many or too few, visible within a cycle of acceptance. A wrong wait counter shows as a stall window that differs from the lock delay plus one, or as a premature or missing error after exactly SETTLE_TO or LOCK_TO cycles. A stale target or old-point register shows up as wrong codes on the command pulses, and on the rollback pulses in particular, by the end of the transition.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_VUP,
    S_FUP,
    S_FDN,
    S_VDN,
    S_RBV
  } dvfs_st_e;
endpackage

// File: rtl/dvfs_optable.sv
module dvfs_optable #(
  parameter int LEVELS = 4,
  parameter int VW = 6,
  parameter int DW = 8,
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [LW-1:0] widx,
  input  logic [VW-1:0] wv,
  input  logic [DW-1:0] wd,
  input  logic [LW-1:0] ra_idx,
  output logic [VW-1:0] ra_v,
  output logic [DW-1:0] ra_d,
  input  logic [LW-1:0] rb_idx,
  output logic [VW-1:0] rb_v,
  output logic [DW-1:0] rb_d
);
  logic [VW-1:0] vt [LEVELS];
  logic [DW-1:0] dt [LEVELS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEVELS; i++) begin
        vt[i] <= VW'((i + 1) * 8);
        dt[i] <= DW'((i + 1) * 4);
      end
    end else if (we) begin
      vt[widx] <= wv;
      dt[widx] <= wd;
    end
  end

  assign ra_v = vt[ra_idx];
  assign ra_d = dt[ra_idx];
  assign rb_v = vt[rb_idx];
  assign rb_d = dt[rb_idx];
endmodule

// File: rtl/dvfs_reqarb.sv
module dvfs_reqarb #(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [LW-1:0] req_level,
  input  logic          therm_alert,
  input  logic          take,
  output logic          pend_valid,
  output logic [LW-1:0] pend_level
);
  logic          therm_q;
  logic          therm_pend;
  logic          sw_pend;
  logic [LW-1:0] sw_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_q    <= 1'b0;
      therm_pend <= 1'b0;
      sw_pend    <= 1'b0;
      sw_lvl     <= '0;
    end else begin
      therm_q <= therm_alert;
      // thermal request: set on rising edge, served first
      if (therm_alert && !therm_q)
        therm_pend <= 1'b1;
      else if (take && therm_pend)
        therm_pend <= 1'b0;
      // software request: newest wins, served when no thermal pending
      if (req_valid) begin
        sw_pend <= 1'b1;
        sw_lvl  <= req_level;
      end else if (take && !therm_pend) begin
        sw_pend <= 1'b0;
      end
    end
  end

  assign pend_valid = therm_pend | sw_pend;
  assign pend_level = therm_pend ? '0 : sw_lvl;
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
  parameter int SETTLE_TO = 64,
  parameter int LOCK_TO = 256,
  localparam int TMAX = (SETTLE_TO > LOCK_TO) ? SETTLE_TO : LOCK_TO,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic sel_lock,
  input  logic ack,
  output logic fire_ack,
  output logic fire_to
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  assign lim      = sel_lock ? TW'(LOCK_TO - 1) : TW'(SETTLE_TO - 1);
  assign fire_ack = run && (cnt != '0) && ack;
  assign fire_to  = run && !fire_ack && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (run && cnt != lim)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int VW = 6,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int SETTLE_TO = 64,
  parameter int LOCK_TO = 256,
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tbl_we,
  input  logic [LW-1:0] tbl_idx,
  input  logic [VW-1:0] tbl_vcode,
  input  logic [DW-1:0] tbl_dcode,
  input  logic          req_valid,
  input  logic [LW-1:0] req_level,
  input  logic          therm_alert,
  output logic          vreg_cmd_valid,
  output logic [VW-1:0] vreg_cmd_code,
  input  logic          vreg_settled,
  output logic          pll_cmd_valid,
  output logic [DW-1:0] pll_cmd_div,
  input  logic          pll_locked,
  output logic          core_stall,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [LW-1:0] cur_level,
  output logic [CW-1:0] cost_cycles,
  output logic [CW-1:0] cost_stall,
  output logic [VW-1:0] cost_swing
);
  dvfs_st_e      st;
  logic          pend_valid;
  logic [LW-1:0] pend_level;
  logic          take;
  logic [VW-1:0] new_v, cur_v, tv, ov;
  logic [DW-1:0] new_d, cur_d, td, od;
  logic [LW-1:0] tgt;
  logic [CW-1:0] tcnt, scnt;
  logic          waiting, sel_lock, ack, fire_ack, fire_to;
  logic [CW-1:0] stall_tot;

  assign take      = (st == S_IDLE) && pend_valid;
  assign waiting   = (st == S_VUP) || (st == S_FUP) || (st == S_FDN) || (st == S_VDN);
  assign sel_lock  = (st == S_FUP) || (st == S_FDN);
  assign ack       = sel_lock ? pll_locked : vreg_settled;
  assign stall_tot = scnt + CW'(core_stall);

  dvfs_reqarb #(.LW(LW)) u_arb (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_level(req_level),
    .therm_alert(therm_alert), .take(take),
    .pend_valid(pend_valid), .pend_level(pend_level)
  );

  dvfs_optable #(.LEVELS(LEVELS), .VW(VW), .DW(DW)) u_tbl (
    .clk(clk), .rst(rst),
    .we(tbl_we), .widx(tbl_idx), .wv(tbl_vcode), .wd(tbl_dcode),
    .ra_idx(pend_level), .ra_v(new_v), .ra_d(new_d),
    .rb_idx(cur_level), .rb_v(cur_v), .rb_d(cur_d)
  );

  dvfs_wait_timer #(.SETTLE_TO(SETTLE_TO), .LOCK_TO(LOCK_TO)) u_tmr (
    .clk(clk), .rst(rst),
    .clear(take | fire_ack | fire_to),
    .run(waiting), .sel_lock(sel_lock), .ack(ack),
    .fire_ack(fire_ack), .fire_to(fire_to)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_IDLE;
      vreg_cmd_valid <= 1'b0;
      vreg_cmd_code  <= '0;
      pll_cmd_valid  <= 1'b0;
      pll_cmd_div    <= '0;
      core_stall     <= 1'b0;
      busy           <= 1'b0;
      done           <= 1'b0;
      err            <= 1'b0;
      cur_level      <= '0;
      cost_cycles    <= '0;
      cost_stall     <= '0;
      cost_swing     <= '0;
      tgt            <= '0;
      tv             <= '0;
      td             <= '0;
      ov             <= '0;
      od             <= '0;
      tcnt           <= '0;
      scnt           <= '0;
    end else begin
      vreg_cmd_valid <= 1'b0;
      pll_cmd_valid  <= 1'b0;
      done           <= 1'b0;
      if (busy && tcnt != '1) tcnt <= tcnt + 1'b1;
      if (core_stall && scnt != '1) scnt <= scnt + 1'b1;

      unique case (st)
        S_IDLE: begin
          if (take) begin
            err  <= 1'b0;
            tgt  <= pend_level;
            tv   <= new_v;
            td   <= new_d;
            ov   <= cur_v;
            od   <= cur_d;
            tcnt <= CW'(1);
            scnt <= '0;
            if (pend_level == cur_level) begin
              done        <= 1'b1;
              cost_cycles <= '0;
              cost_stall  <= '0;
              cost_swing  <= '0;
            end else if (pend_level > cur_level) begin
              st             <= S_VUP;
              busy           <= 1'b1;
              vreg_cmd_valid <= 1'b1;
              vreg_cmd_code  <= new_v;
            end else begin
              st            <= S_FDN;
              busy          <= 1'b1;
              pll_cmd_valid <= 1'b1;
              pll_cmd_div   <= new_d;
              core_stall    <= 1'b1;
            end
          end
        end

        S_VUP: begin
          if (fire_ack) begin
            st            <= S_FUP;
            pll_cmd_valid <= 1'b1;
            pll_cmd_div   <= td;
            core_stall    <= 1'b1;
          end else if (fire_to) begin
            err            <= 1'b1;
            vreg_cmd_valid <= 1'b1;
            vreg_cmd_code  <= ov;
            st             <= S_IDLE;
            busy           <= 1'b0;
            done           <= 1'b1;
            cost_cycles    <= tcnt;
            cost_stall     <= stall_tot;
            cost_swing     <= '0;
          end
        end

        S_FUP, S_VDN: begin
          if (fire_ack) begin
            core_stall  <= 1'b0;
            st          <= S_IDLE;
            busy        <= 1'b0;
            done        <= 1'b1;
            cur_level   <= tgt;
            cost_cycles <= tcnt;
            cost_stall  <= stall_tot;
            cost_swing  <= (tv > ov) ? (tv - ov) : (ov - tv);
          end else if (fire_to) begin
            err           <= 1'b1;
            core_stall    <= 1'b0;
            pll_cmd_valid <= 1'b1;
            pll_cmd_div   <= od;
            st            <= S_RBV;
          end
        end

        S_FDN: begin
          if (fire_ack) begin
            core_stall     <= 1'b0;
            st             <= S_VDN;
            vreg_cmd_valid <= 1'b1;
            vreg_cmd_code  <= tv;
          end else if (fire_to) begin
            err           <= 1'b1;
            core_stall    <= 1'b0;
            pll_cmd_valid <= 1'b1;
            pll_cmd_div   <= od;
            st            <= S_IDLE;
            busy          <= 1'b0;
            done          <= 1'b1;
            cost_cycles   <= tcnt;
            cost_stall    <= stall_tot;
            cost_swing    <= '0;
          end
        end

        S_RBV: begin
          vreg_cmd_valid <= 1'b1;
          vreg_cmd_code  <= ov;
          st             <= S_IDLE;
          busy           <= 1'b0;
          done           <= 1'b1;
          cost_cycles    <= tcnt;
          cost_stall     <= stall_tot;
          cost_swing     <= '0;
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk (
  input logic clk,
  input logic rst,
  input logic vreg_cmd_valid,
  input logic pll_cmd_valid,
  input logic core_stall,
  input logic busy,
  input logic done,
  input logic err
);
  // R3 / R4: regulator and PLL are never commanded in the same cycle
  a_r3_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(vreg_cmd_valid && pll_cmd_valid));

  // R5: stall only starts together with a PLL command
  a_r5_stall_with_pll: assert property (@(posedge clk) disable iff (rst)
    $rose(core_stall) |-> pll_cmd_valid);

  // R5: stall only inside a transition
  a_r5_stall_in_busy: assert property (@(posedge clk) disable iff (rst)
    core_stall |-> busy);

  // R10: done pulse comes with busy low
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: an error releases the core
  a_r9_err_unstalls: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !core_stall);
endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
  .clk(clk), .rst(rst),
  .vreg_cmd_valid(vreg_cmd_valid), .pll_cmd_valid(pll_cmd_valid),
  .core_stall(core_stall), .busy(busy), .done(done), .err(err)
);

// File: tb/dvfs_seq_test.sv
module dvfs_seq_test;
  localparam int LEVELS = 4;
  localparam int VW = 6;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int STO = 16;
  localparam int LTO = 32;
  localparam int NEVER = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_idx = '0;
  logic [VW-1:0] tbl_vcode = '0;
  logic [DW-1:0] tbl_dcode = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_level = '0;
  logic therm_alert = 1'b0;
  logic vreg_cmd_valid, pll_cmd_valid, core_stall, busy, done, err;
  logic [VW-1:0] vreg_cmd_code, cost_swing;
  logic [DW-1:0] pll_cmd_div;
  logic vreg_settled = 1'b1;
  logic pll_locked = 1'b1;
  logic [1:0] cur_level;
  logic [CW-1:0] cost_cycles, cost_stall;

  always #5 clk = ~clk;

  dvfs_seq #(.LEVELS(LEVELS), .VW(VW), .DW(DW), .CW(CW),
             .SETTLE_TO(STO), .LOCK_TO(LTO)) uut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_vcode(tbl_vcode), .tbl_dcode(tbl_dcode),
    .req_valid(req_valid), .req_level(req_level), .therm_alert(therm_alert),
    .vreg_cmd_valid(vreg_cmd_valid), .vreg_cmd_code(vreg_cmd_code),
    .vreg_settled(vreg_settled), .pll_cmd_valid(pll_cmd_valid),
    .pll_cmd_div(pll_cmd_div), .pll_locked(pll_locked),
    .core_stall(core_stall), .busy(busy), .done(done), .err(err),
    .cur_level(cur_level), .cost_cycles(cost_cycles),
    .cost_stall(cost_stall), .cost_swing(cost_swing)
  );

  int checks = 0;
  int errors = 0;
  int bt_v [LEVELS];
  int bt_d [LEVELS];
  int sd_cfg = 1, pd_cfg = 1;
  int rcnt = 0, pcnt = 0;
  int nev = 0;
  int ev_kind [8];
  int ev_code [8];
  int stall_n = 0, bad_stall = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // regulator and PLL models
  always @(negedge clk) begin
    if (vreg_cmd_valid) begin
      vreg_settled <= 1'b0;
      rcnt <= (sd_cfg == NEVER) ? 0 : sd_cfg;
    end else if (rcnt == 1) begin
      vreg_settled <= 1'b1;
      rcnt <= 0;
    end else if (rcnt > 1) begin
      rcnt <= rcnt - 1;
    end
    if (pll_cmd_valid) begin
      pll_locked <= 1'b0;
      pcnt <= (pd_cfg == NEVER) ? 0 : pd_cfg;
    end else if (pcnt == 1) begin
      pll_locked <= 1'b1;
      pcnt <= 0;
    end else if (pcnt > 1) begin
      pcnt <= pcnt - 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (vreg_cmd_valid && nev < 8) begin
      ev_kind[nev] = 1; ev_code[nev] = int'(vreg_cmd_code); nev++;
    end
    if (pll_cmd_valid && nev < 8) begin
      ev_kind[nev] = 2; ev_code[nev] = int'(pll_cmd_div); nev++;
    end
    if (core_stall) stall_n++;
    if (core_stall && !vreg_settled) bad_stall++;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_log();
    nev = 0; stall_n = 0; bad_stall = 0;
  endtask

  task automatic issue(int lvl);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = 2'(lvl);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!done && n < 2000);
    chk(done, tag, 0, 1);
  endtask

  // kind: 0 same, 1 up, 2 down
  task automatic check_move(int from, int to, int sd, int pd);
    int kind;
    kind = (to == from) ? 0 : ((to > from) ? 1 : 2);
    chk(int'(cur_level) == to, "R1 level", int'(cur_level), to);
    chk(busy == 1'b0, "R10 busy at done", int'(busy), 0);
    chk(err == 1'b0, "R10 err clear", int'(err), 0);
    if (kind == 0) begin
      chk(nev == 0, "R6 no commands", nev, 0);
      chk(cost_cycles == 0, "R6 cost zero", int'(cost_cycles), 0);
    end else begin
      chk(nev == 2, "R3 command count", nev, 2);
      if (kind == 1) begin
        chk(ev_kind[0] == 1 && ev_code[0] == bt_v[to], "R3 voltage first", ev_code[0], bt_v[to]);
        chk(ev_kind[1] == 2 && ev_code[1] == bt_d[to], "R3 divider second", ev_code[1], bt_d[to]);
      end else begin
        chk(ev_kind[0] == 2 && ev_code[0] == bt_d[to], "R4 divider first", ev_code[0], bt_d[to]);
        chk(ev_kind[1] == 1 && ev_code[1] == bt_v[to], "R4 voltage second", ev_code[1], bt_v[to]);
      end
      chk(stall_n == pd + 1, "R5 stall window", stall_n, pd + 1);
      chk(bad_stall == 0, "R5 no stall on voltage", bad_stall, 0);
      chk(int'(cost_cycles) == sd + pd + 2, "R11 cost_cycles", int'(cost_cycles), sd + pd + 2);
      chk(int'(cost_stall) == pd + 1, "R11 cost_stall", int'(cost_stall), pd + 1);
      chk(int'(cost_swing) == ((bt_v[to] > bt_v[from]) ? bt_v[to] - bt_v[from] : bt_v[from] - bt_v[to]),
          "R11 cost_swing", int'(cost_swing), bt_v[to] - bt_v[from]);
    end
  endtask

  // {level[1:0], settle delay[7:0], lock delay[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {2'd2, 8'd3, 8'd5},
    {2'd3, 8'd1, 8'd2},
    {2'd1, 8'd4, 8'd3},
    {2'd1, 8'd0, 8'd0},
    {2'd0, 8'd2, 8'd6},
    {2'd3, 8'd5, 8'd1}
  };

  initial begin
    int cur;
    for (int i = 0; i < LEVELS; i++) begin
      bt_v[i] = 8 * (i + 1);
      bt_d[i] = 4 * (i + 1);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 / R10 reset state
    chk(cur_level == 0, "R1 reset level", int'(cur_level), 0);
    chk(!busy && !done && !err && !core_stall, "R10 reset outputs",
        int'({busy, done, err, core_stall}), 0);

    cur = 0;
    for (int k = 0; k < 6; k++) begin
      int lvl, sd, pd;
      lvl = int'(VEC[k][17:16]);
      sd = int'(VEC[k][15:8]);
      pd = int'(VEC[k][7:0]);
      sd_cfg = (sd == 0) ? 1 : sd;
      pd_cfg = (pd == 0) ? 1 : pd;
      clear_log();
      issue(lvl);
      wait_done("R10 done vector");
      check_move(cur, lvl, sd, pd);
      cur = lvl;
    end

    // R7: thermal and software together at level 3; thermal first
    sd_cfg = 2; pd_cfg = 3;
    clear_log();
    @(negedge clk);
    therm_alert = 1'b1;
    req_valid = 1'b1;
    req_level = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R7 thermal done");
    check_move(3, 0, 2, 3);
    clear_log();
    wait_done("R7 software after thermal");
    check_move(0, 2, 2, 3);
    therm_alert = 1'b0;

    // R2: requests during busy, newest wins
    sd_cfg = 4; pd_cfg = 4;
    clear_log();
    issue(1);
    issue(3);
    issue(0);
    wait_done("R2 first done");
    check_move(2, 1, 4, 4);
    clear_log();
    wait_done("R2 latched done");
    check_move(1, 0, 4, 4);
    chk(int'(cur_level) == 0, "R2 newest request wins", int'(cur_level), 0);

    // R8: regulator timeout on speed-up
    sd_cfg = NEVER; pd_cfg = 2;
    clear_log();
    issue(2);
    wait_done("R8 done");
    chk(err == 1'b1, "R8 err set", int'(err), 1);
    chk(int'(cur_level) == 0, "R8 level kept", int'(cur_level), 0);
    chk(nev == 2 && ev_kind[1] == 1 && ev_code[1] == bt_v[0], "R8 voltage restored", ev_code[1], bt_v[0]);
    chk(stall_n == 0, "R8 no stall", stall_n, 0);
    @(negedge clk);
    sd_cfg = 1;
    vreg_settled <= 1'b1;
    @(negedge clk);

    // R9: PLL timeout on speed-up
    sd_cfg = 2; pd_cfg = NEVER;
    clear_log();
    issue(2);
    wait_done("R9 done");
    @(negedge clk); #1;
    chk(err == 1'b1, "R9 err set", int'(err), 1);
    chk(int'(cur_level) == 0, "R9 level kept", int'(cur_level), 0);
    chk(nev == 4, "R9 command count", nev, 4);
    chk(ev_kind[2] == 2 && ev_code[2] == bt_d[0], "R9 divider restored", ev_code[2], bt_d[0]);
    chk(ev_kind[3] == 1 && ev_code[3] == bt_v[0], "R9 voltage restored after", ev_code[3], bt_v[0]);
    chk(stall_n == LTO, "R9 stall bounded", stall_n, LTO);
    chk(!core_stall, "R9 stall released", int'(core_stall), 0);
    pd_cfg = 1;
    pll_locked <= 1'b1;
    @(negedge clk);

    // R10 / R1: recovery clears err, table write used
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'd3; tbl_vcode = 6'd50; tbl_dcode = 8'd200;
    @(negedge clk);
    tbl_we = 1'b0;
    bt_v[3] = 50; bt_d[3] = 200;
    sd_cfg = 3; pd_cfg = 2;
    clear_log();
    issue(3);
    wait_done("R1 table write done");
    check_move(0, 3, 3, 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule